// File: doc/BRIEF.md
# Calendar Alarm With Repeat Masks

This block keeps the four alarm settings of a calendar clock: seconds, minutes, hours and day of month. Each setting is one BCD byte, and its top bit is a repeat mask. An external time-of-day counter supplies the current BCD time and a one-second strobe. On every strobe the block compares the alarm settings with the time. It raises a one-cycle interrupt pulse when the fields selected by the repeat mode agree.

Software reaches the settings through a byte-wide register port. Every write to an alarm setting is range-checked, and a byte that decodes out of range is dropped with no other effect. A separate control byte holds the alarm enable. The combination of mask bits selects the repeat period, from monthly down to every second.

A small controller sequences each evaluation:
- `ST_IDLE` waits for the strobe and latches the time into a snapshot. Transition: tick → `ST_CHECK`.
- `ST_CHECK` evaluates the compare. Transitions: hit with enable → `ST_FIRE`, otherwise → `ST_IDLE`.
- `ST_FIRE` drives the pulse for one cycle. Transition: always → `ST_IDLE`.

Top module: `cal_alarm`

## Requirements
- R1: After reset all four alarm registers and the control register read 0x00, and `alarm_irq` is low.
- R2: A write to seconds (address 0) or minutes (address 1) is stored only when 10*wdata[6:4]+wdata[3:0] is at most 59; otherwise the register keeps its old value.
- R3: A write to hours (address 2) is stored only when 10*wdata[5:4]+wdata[3:0] is at most 23; otherwise it is dropped.
- R4: A write to date (address 3) is stored only when 10*wdata[4]+wdata[3:0] is nonzero; otherwise it is dropped.
- R5: A read of addresses 0 to 3 returns the exact byte last stored, bit 7 included. Address 4 returns the control byte. Addresses 5 to 7 read 0x00, and writes to them change no register.
- R6: With bit 7 clear in all four alarm registers (monthly mode), a pulse needs date[5:0], hours[5:0], minutes[6:0] and seconds[6:0] to all equal the time inputs.
- R7: With only the date mask set (daily mode), hours, minutes and seconds must match.
- R8: With only the date and hours masks set (hourly mode), minutes and seconds must match.
- R9: With the date, hours and minutes masks set and the seconds mask clear (minute mode), only seconds must match.
- R10: Any other mask combination fires on every tick.
- R11: The compare runs only on a cycle with `sec_tick` high, using the time sampled at that edge. A hit gives exactly one pulse, high in the second cycle after that edge.
- R12: Bit 0 of the control register (address 4) enables the alarm; while it is clear no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tod_sec | input | 8 | Current seconds, BCD |
| tod_min | input | 8 | Current minutes, BCD |
| tod_hour | input | 8 | Current hours, BCD |
| tod_date | input | 8 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle strobe once per second |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
Write validation is swept over all 256 byte values for each of the four alarm registers, and every value is read back against an arithmetic decode. This separates the field width each register checks (seven, six or five bits) and its bound. The compare is tried with all sixteen mask combinations, each against five time patterns: a full match, and one field off in each of seconds, minutes, hours and date. Each pattern shows which fields a given mode ignores. Ticks withheld while the time matches, and a cleared enable bit, show that the compare is gated by the strobe and the enable.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int BYTE_W   = 8;
    localparam int NFIELD   = 4;
    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_DATE = 3;
    localparam int ADDR_CTL = 4;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MIN,
        RPT_SEC
    } repeat_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FIRE
    } ctl_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } cal_t;

    // tens*10 + units; the largest case (7,15) = 85 fits in seven bits
    function automatic logic [6:0] bcd_decode(input logic [2:0] tens, input logic [3:0] units);
        return ({4'b0, tens} * 7'd10) + {3'b0, units};
    endfunction

    function automatic logic field_accepts(input int unsigned idx, input logic [BYTE_W-1:0] d);
        logic ok;
        case (idx)
            FLD_SEC, FLD_MIN: ok = bcd_decode(d[6:4], d[3:0]) <= 7'd59;
            FLD_HOUR:         ok = bcd_decode({1'b0, d[5:4]}, d[3:0]) <= 7'd23;
            FLD_DATE:         ok = bcd_decode({2'b0, d[4]}, d[3:0]) != 7'd0;
            default:          ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output cal_t              alarm,
    output logic              irq_en
);

    logic [BYTE_W-1:0] fld_q [NFIELD];
    logic [BYTE_W-1:0] ctl_q;
    logic [NFIELD-1:0] fld_ok;
    logic [NFIELD-1:0] fld_sel;

    generate
        for (genvar i = 0; i < NFIELD; i++) begin : g_fld
            assign fld_sel[i] = (addr == ADDR_W'(i));
            assign fld_ok[i]  = field_accepts(i, wdata);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fld_q[i] <= '0;
                end else if (we && fld_sel[i] && fld_ok[i]) begin
                    fld_q[i] <= wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we && addr == ADDR_W'(ADDR_CTL)) begin
            ctl_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NFIELD; i++) begin
            if (fld_sel[i]) rdata = fld_q[i];
        end
        if (addr == ADDR_W'(ADDR_CTL)) rdata = ctl_q;
    end

    assign alarm.sec  = fld_q[FLD_SEC];
    assign alarm.min  = fld_q[FLD_MIN];
    assign alarm.hour = fld_q[FLD_HOUR];
    assign alarm.date = fld_q[FLD_DATE];
    assign irq_en     = ctl_q[0];

endmodule

// File: rtl/cal_alarm_mode.sv
module cal_alarm_mode
    import cal_alarm_pkg::*;
(
    input  logic [NFIELD-1:0] mask,
    output repeat_e           mode
);

    logic only_date, date_hour, date_hour_min;

    assign only_date     = (mask == 4'b1000);
    assign date_hour     = (mask == 4'b1100);
    assign date_hour_min = (mask == 4'b1110);

    always_comb begin
        if (mask == '0)         mode = RPT_MONTH;
        else if (only_date)     mode = RPT_DAY;
        else if (date_hour)     mode = RPT_HOUR;
        else if (date_hour_min) mode = RPT_MIN;
        else                    mode = RPT_SEC;
    end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  repeat_e mode,
    input  cal_t    alarm,
    input  cal_t    now,
    output logic    hit
);

    logic sec_eq, min_eq, hour_eq, date_eq;

    assign sec_eq  = alarm.sec[6:0]  == now.sec[6:0];
    assign min_eq  = alarm.min[6:0]  == now.min[6:0];
    assign hour_eq = alarm.hour[5:0] == now.hour[5:0];
    assign date_eq = alarm.date[5:0] == now.date[5:0];

    always_comb begin
        unique case (mode)
            RPT_MONTH: hit = date_eq && hour_eq && min_eq && sec_eq;
            RPT_DAY:   hit = hour_eq && min_eq && sec_eq;
            RPT_HOUR:  hit = min_eq && sec_eq;
            RPT_MIN:   hit = sec_eq;
            RPT_SEC:   hit = 1'b1;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        tod_sec,
    input  logic [7:0]        tod_min,
    input  logic [7:0]        tod_hour,
    input  logic [7:0]        tod_date,
    input  logic              sec_tick,
    output logic              alarm_irq
);

    cal_t        alarm_cfg;
    logic        irq_en;
    repeat_e     mode;
    logic        hit;
    cal_t        snap_q;
    ctl_state_e  state_q, state_d;

    cal_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .alarm  (alarm_cfg),
        .irq_en (irq_en)
    );

    cal_alarm_mode u_mode (
        .mask ({alarm_cfg.date[7], alarm_cfg.hour[7], alarm_cfg.min[7], alarm_cfg.sec[7]}),
        .mode (mode)
    );

    cal_alarm_match u_match (
        .mode  (mode),
        .alarm (alarm_cfg),
        .now   (snap_q),
        .hit   (hit)
    );

    // state register and time snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && sec_tick) begin
                snap_q <= '{date: tod_date, hour: tod_hour, min: tod_min, sec: tod_sec};
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sec_tick) state_d = ST_CHECK;
            ST_CHECK: state_d = (hit && irq_en) ? ST_FIRE : ST_IDLE;
            ST_FIRE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        alarm_irq = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              sec_tick,
    input logic              alarm_irq,
    input cal_t              alarm_cfg,
    input logic              irq_en
);

    logic [6:0] sec_val, hour_val, date_val;
    assign sec_val  = ({4'b0, reg_wdata[6:4]} * 7'd10) + {3'b0, reg_wdata[3:0]};
    assign hour_val = ({5'b0, reg_wdata[5:4]} * 7'd10) + {3'b0, reg_wdata[3:0]};
    assign date_val = ({6'b0, reg_wdata[4]} * 7'd10) + {3'b0, reg_wdata[3:0]};

    // R11
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |=> !alarm_irq);

    // R11
    pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> $past(sec_tick, 2));

    // R12
    pulse_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> $past(irq_en));

    // R2
    sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(FLD_SEC) && sec_val > 7'd59) |=> $stable(alarm_cfg.sec));

    // R2
    sec_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(FLD_SEC) && sec_val <= 7'd59) |=> alarm_cfg.sec == $past(reg_wdata));

    // R3
    hour_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(FLD_HOUR) && hour_val > 7'd23) |=> $stable(alarm_cfg.hour));

    // R4
    date_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(FLD_DATE) && date_val == 7'd0) |=> $stable(alarm_cfg.date));

endmodule

bind cal_alarm cal_alarm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sec_tick  (sec_tick),
    .alarm_irq (alarm_irq),
    .alarm_cfg (alarm_cfg),
    .irq_en    (irq_en)
);

// File: tb/cal_alarm_bench.sv
module cal_alarm_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] tod_sec = '0, tod_min = '0, tod_hour = '0, tod_date = '0;
    logic       sec_tick = 1'b0;
    logic       alarm_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [4];

    always #5 clk = ~clk;

    cal_alarm u_cal_alarm (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tod_sec(tod_sec),
        .tod_min(tod_min), .tod_hour(tod_hour), .tod_date(tod_date),
        .sec_tick(sec_tick), .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = 8'(d); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = int'(reg_rdata);
    endtask

    function automatic bit accepts(input int r, input int v);
        int u = v & 15;
        case (r)
            0, 1:    return (((v >> 4) & 7) * 10 + u) <= 59;
            2:       return (((v >> 4) & 3) * 10 + u) <= 23;
            default: return (((v >> 4) & 1) * 10 + u) != 0;
        endcase
    endfunction

    // mask bit order: 0 seconds, 1 minutes, 2 hours, 3 date
    function automatic bit exp_fire(input int m, input bit se, input bit me, input bit he, input bit de);
        case (m)
            0:       return de && he && me && se;
            8:       return he && me && se;
            12:      return me && se;
            14:      return se;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string mode_req(input int m);
        case (m)
            0: return "R6";
            8: return "R7";
            12: return "R8";
            14: return "R9";
            default: return "R10";
        endcase
    endfunction

    // one tick; returns the irq value seen in the second cycle after the edge
    task automatic tick_probe(input string req, output int mid);
        int s0, s2;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; s0 = int'(alarm_irq);
        @(negedge clk); mid = int'(alarm_irq);
        @(negedge clk); s2 = int'(alarm_irq);
        check({req, " R11 no early pulse"}, s0, 0);
        check({req, " R11 single pulse"}, s2, 0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            check("R1 reset value", v, 0);
        end
        check("R1 irq low", int'(alarm_irq), 0);

        // R2 R3 R4 R5 exhaustive write validation
        for (int r = 0; r < 4; r++) shadow[r] = 8'h00;
        for (int r = 0; r < 4; r++) begin
            for (int d = 0; d < 256; d++) begin
                wr(r, d);
                if (accepts(r, d)) shadow[r] = 8'(d);
                rd(r, v);
                check(r < 2 ? "R2 sec/min validation" : (r == 2 ? "R3 hour validation" : "R4 date validation"),
                      v, int'(shadow[r]));
            end
        end

        // R5 control readback and unused addresses
        wr(4, 8'hA6);
        rd(4, v); check("R5 control readback", v, 8'hA6);
        for (int a = 5; a < 8; a++) begin
            wr(a, 8'hFF);
            rd(a, v); check("R5 unused reads zero", v, 0);
        end
        for (int r = 0; r < 4; r++) begin
            rd(r, v); check("R5 unused write no effect", v, int'(shadow[r]));
        end

        // R6..R10 mask sweep: 16 mask combinations x 5 time patterns
        wr(4, 8'h01);
        for (int m = 0; m < 16; m++) begin
            wr(0, 8'h45 | (m[0] ? 8'h80 : 8'h00));
            wr(1, 8'h32 | (m[1] ? 8'h80 : 8'h00));
            wr(2, 8'h17 | (m[2] ? 8'h80 : 8'h00));
            wr(3, 8'h28 | (m[3] ? 8'h80 : 8'h00));
            rd(0, v); check("R5 mask bit kept", v, 8'h45 | (m[0] ? 8'h80 : 8'h00));
            for (int pat = 0; pat < 5; pat++) begin
                tod_sec  = (pat == 1) ? 8'hC6 : 8'hC5;
                tod_min  = (pat == 2) ? 8'h33 : 8'h32;
                tod_hour = (pat == 3) ? 8'h18 : 8'h17;
                tod_date = (pat == 4) ? 8'h29 : 8'h28;
                tick_probe(mode_req(m), p);
                check({mode_req(m), " fire decision"}, p,
                      int'(exp_fire(m, pat != 1, pat != 2, pat != 3, pat != 4)));
            end
        end

        // R11 no compare without tick (every-second mode, time matching)
        wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h00); wr(3, 8'h01);
        p = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk); if (alarm_irq) p++;
        end
        check("R11 no pulse without tick", p, 0);

        // R11 time sampled at the tick edge: minute mode, seconds match only at edge
        wr(0, 8'h10); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h81);
        tod_sec = 8'h10;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; tod_sec = 8'h11;
        @(negedge clk); check("R11 snapshot at tick", int'(alarm_irq), 1);
        @(negedge clk); check("R11 pulse one cycle", int'(alarm_irq), 0);

        // R12 enable gating
        wr(0, 8'h80); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h01);
        wr(4, 8'h00);
        tick_probe("R12", p); check("R12 disabled no pulse", p, 0);
        wr(4, 8'hFE);
        tick_probe("R12", p); check("R12 bit0 clear no pulse", p, 0);
        wr(4, 8'h01);
        tick_probe("R12", p); check("R12 enabled pulse", p, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule